// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by fixed priority and presents one interrupt output to a processor. Software talks to it through two byte-wide addresses. The command address takes setup and housekeeping commands. The data address takes setup words and, once setup is done, the mask. Before it does anything useful, a fixed sequence of setup words must be written. That sequence sets the vector base, the map of lines that have a second controller behind them, and whether in-service bits are cleared automatically.

The processor acknowledges with a one-cycle `inta` pulse. In that cycle the block returns an 8-bit vector and moves the winning request from the pending set into the in-service set. An in-service bit then blocks its own level and every lower level until an end-of-interrupt command clears it. If nothing can win when the acknowledge arrives, the block returns the vector of the lowest-priority line and marks nothing as in service. Two of these blocks can be chained. The first one's setup map names the input that carries the second one, and `cas_hit` tells the system when the winning line is such an input.

The setup sequence is a small state machine. Its states are:
- `ST_UNINIT`: after reset; waits for the first setup word.
- `ST_ICW2`: waits for the vector-base word.
- `ST_ICW3`: waits for the chaining word.
- `ST_ICW4`: waits for the mode word.
- `ST_READY`: normal operation.

Its transitions are:
- From any state, a command-address write with bit 4 set goes to `ST_ICW2`.
- `ST_ICW2` goes on a data write to `ST_ICW3` in chained mode. In single mode it goes to `ST_ICW4` if a mode word was announced, and otherwise to `ST_READY`.
- `ST_ICW3` goes on a data write to `ST_ICW4` if a mode word was announced, and otherwise to `ST_READY`.
- `ST_ICW4` goes on a data write to `ST_READY`.

Top module: `pic_top`

## Requirements
- R1: After reset the mask reads back 0xFF at the data address and the pending set reads back 0x00 at the command address. While setup is incomplete, `int_o` stays low and an `inta` pulse gives `vec_valid` low.
- R2: A command-address write with bit 4 set starts setup. Its bit 0 announces a mode word and its bit 1 selects single (unchained) mode. It clears the mask, the pending set and the in-service set, clears automatic clearing, and selects the pending set for command reads. The data writes that follow are taken as the vector base, then the chaining map (skipped in single mode), then the mode word (skipped if not announced). None of them changes the mask.
- R3: In `ST_READY`, a data-address write loads the mask and a data-address read returns it. A set mask bit keeps that line from raising `int_o`.
- R4: A rising edge on `ir[n]` sets pending bit n. A line held high does not set the bit again after it is acknowledged.
- R5: `int_o` is high in `ST_READY` exactly when the highest-priority unmasked pending line (line 0 highest) has a higher priority than every in-service line.
- R6: During an `inta` pulse that a line wins, `vec_valid` is high and `vec` = {base word bits 7:3, winning line number} in the same cycle. After that edge the line's pending bit is clear and its in-service bit is set.
- R7: During an `inta` pulse that no line wins, `vec` carries line number 7 on top of the base. This holds even when line 7 is masked, and the pending and in-service sets do not change.
- R8: A command write of 0x60 plus level L (0..7) clears only in-service bit L. A command write of 0x20 clears the highest-priority set in-service bit.
- R9: Mode-word bit 1 set selects automatic clearing: an acknowledge never sets an in-service bit.
- R10: `cas_hit` is high during an acknowledge exactly when setup chose chained mode and the chaining-map bit of the winning line is set. It is never high in single mode or on a no-winner acknowledge.
- R11: A command write of 0x0B selects the in-service set for command-address reads, and a command write of 0x0A selects the pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the current `addr` |
| ir | input | LINES | Interrupt request lines |
| inta | input | 1 | One-cycle acknowledge pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | `vec` is valid in this cycle |
| vec | output | DW | Acknowledge vector |
| cas_hit | output | 1 | Winning line carries a chained controller |

## Verification
A wrong in-service set shows up at the ports in several ways. `int_o` can be wrongly held low for a lower line. An acknowledge can return a spurious line-7 vector where a real line should win, or the reverse. Either shows within a cycle of the next request or acknowledge. A setup sequencer that is out of step puts setup words into the mask, or a later mask write into a setup register. A mask read-back or a shifted vector base at the next acknowledge exposes this. An edge detector that re-arms on a held level gives a second `int_o` with no new edge. All of these faults can be read back within a few cycles, through the register reads or the acknowledge vector.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_ICW2,
        ST_ICW3,
        ST_ICW4,
        ST_READY
    } init_st_t;

    localparam logic [2:0] OP_NS_EOI = 3'b001;
    localparam logic [2:0] OP_SP_EOI = 3'b011;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       icw1_wr,
    input  logic       data_wr,
    input  logic [1:0] mode_bits,
    output logic       ready,
    output logic       ld_base,
    output logic       ld_cas,
    output logic       ld_mode,
    output logic       single
);
    init_st_t state_q, state_n;
    logic     ic4_q, sngl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_UNINIT;
            ic4_q   <= 1'b0;
            sngl_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            if (icw1_wr) begin
                ic4_q  <= mode_bits[0];
                sngl_q <= mode_bits[1];
            end
        end
    end

    always_comb begin
        state_n = state_q;
        ld_base = 1'b0;
        ld_cas  = 1'b0;
        ld_mode = 1'b0;
        if (icw1_wr) begin
            state_n = ST_ICW2;
        end else begin
            unique case (state_q)
                ST_UNINIT: state_n = ST_UNINIT;
                ST_ICW2: if (data_wr) begin
                    ld_base = 1'b1;
                    if (!sngl_q)    state_n = ST_ICW3;
                    else if (ic4_q) state_n = ST_ICW4;
                    else            state_n = ST_READY;
                end
                ST_ICW3: if (data_wr) begin
                    ld_cas  = 1'b1;
                    state_n = ic4_q ? ST_ICW4 : ST_READY;
                end
                ST_ICW4: if (data_wr) begin
                    ld_mode = 1'b1;
                    state_n = ST_READY;
                end
                ST_READY: state_n = ST_READY;
                default:  state_n = ST_UNINIT;
            endcase
        end
    end

    assign ready  = (state_q == ST_READY);
    assign single = sngl_q;
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [LINES-1:0] ir,
    input  logic             inta,
    output logic             int_o,
    output logic             vec_valid,
    output logic [DW-1:0]    vec,
    output logic             cas_hit
);
    localparam int LVL_W = $clog2(LINES);
    localparam int BASE_W = DW - LVL_W;

    logic [LINES-1:0]  irr_q, isr_q, imr_q, cas_map_q, ir_q, isr_n;
    logic [BASE_W-1:0] base_q;
    logic              aeoi_q, sel_isr_q;
    logic              ready, single, ld_base, ld_cas, ld_mode;
    logic              cmd_wr, data_wr, icw1_wr, ocw_wr, mask_wr;
    logic              cand_v, isr_v, grant, ack_take;
    logic [LVL_W-1:0]  cand_i, isr_i, ack_lvl;

    assign cmd_wr  = wr_en & ~addr;
    assign data_wr = wr_en & addr;
    assign icw1_wr = cmd_wr & wdata[4];
    assign ocw_wr  = cmd_wr & ~wdata[4] & ready;
    assign mask_wr = data_wr & ready;

    pic_init_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .icw1_wr   (icw1_wr),
        .data_wr   (data_wr),
        .mode_bits (wdata[1:0]),
        .ready     (ready),
        .ld_base   (ld_base),
        .ld_cas    (ld_cas),
        .ld_mode   (ld_mode),
        .single    (single)
    );

    pic_prio #(.W(LINES)) u_req_prio (
        .req   (irr_q & ~imr_q),
        .found (cand_v),
        .idx   (cand_i)
    );

    pic_prio #(.W(LINES)) u_isr_prio (
        .req   (isr_q),
        .found (isr_v),
        .idx   (isr_i)
    );

    assign grant     = ready & cand_v & (~isr_v | (cand_i < isr_i));
    assign int_o     = grant;
    assign vec_valid = inta & ready;
    assign ack_take  = vec_valid & grant;
    assign ack_lvl   = grant ? cand_i : LVL_W'(LINES - 1);
    assign vec       = vec_valid ? {base_q, ack_lvl} : '0;
    assign cas_hit   = ack_take & ~single & cas_map_q[cand_i];
    assign rdata     = addr ? DW'(imr_q) : DW'(sel_isr_q ? isr_q : irr_q);

    always_comb begin
        isr_n = isr_q;
        if (ack_take && !aeoi_q) isr_n[cand_i] = 1'b1;
        if (ocw_wr && !wdata[3]) begin
            if (wdata[7:5] == OP_NS_EOI && isr_v) isr_n[isr_i] = 1'b0;
            if (wdata[7:5] == OP_SP_EOI)          isr_n[wdata[LVL_W-1:0]] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q      <= '0;
            irr_q     <= '0;
            isr_q     <= '0;
            imr_q     <= '1;
            cas_map_q <= '0;
            base_q    <= '0;
            aeoi_q    <= 1'b0;
            sel_isr_q <= 1'b0;
        end else begin
            ir_q <= ir;
            if (icw1_wr) begin
                irr_q     <= '0;
                isr_q     <= '0;
                imr_q     <= '0;
                aeoi_q    <= 1'b0;
                sel_isr_q <= 1'b0;
            end else begin
                irr_q <= (irr_q & ~(ack_take ? (LINES'(1) << cand_i) : '0))
                       | (ir & ~ir_q);
                isr_q <= isr_n;
                if (mask_wr) imr_q <= wdata[LINES-1:0];
                if (ld_base) base_q <= wdata[DW-1:LVL_W];
                if (ld_cas)  cas_map_q <= wdata[LINES-1:0];
                if (ld_mode) aeoi_q <= wdata[1];
                if (ocw_wr && wdata[3] && wdata[1]) sel_isr_q <= wdata[0];
            end
        end
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int LINES = 8,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             addr,
    input logic [DW-1:0]    wdata,
    input logic             inta,
    input logic             int_o,
    input logic             vec_valid,
    input logic [DW-1:0]    vec,
    input logic             cas_hit,
    input logic             ready,
    input logic             aeoi,
    input logic             single,
    input logic [LINES-1:0] irr,
    input logic [LINES-1:0] isr,
    input logic [LINES-1:0] imr
);
    localparam int LVL_W = $clog2(LINES);

    assert_no_int_uninit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!int_o && !vec_valid));

    assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((irr & ~imr) != '0));

    assert_ack_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && int_o && !aeoi && !wr_en) |=> ($countones(isr & ~$past(isr)) == 1));

    assert_spurious_keeps_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !int_o && !wr_en) |=> (isr == $past(isr)));

    assert_spurious_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !int_o) |-> (vec[LVL_W-1:0] == {LVL_W{1'b1}}));

    assert_spec_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && !addr && wdata[7:3] == 5'b01100 && !inta)
        |=> (isr[$past(wdata[LVL_W-1:0])] == 1'b0));

    assert_aeoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && aeoi && !wr_en) |=> (isr == $past(isr)));

    assert_cas_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas_hit |-> (vec_valid && int_o && !single));
endmodule

bind pic_top pic_checker #(.LINES(LINES), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .inta      (inta),
    .int_o     (int_o),
    .vec_valid (vec_valid),
    .vec       (vec),
    .cas_hit   (cas_hit),
    .ready     (ready),
    .aeoi      (aeoi_q),
    .single    (single),
    .irr       (irr_q),
    .isr       (isr_q),
    .imr       (imr_q)
);

// File: tb/pic_top_tb.sv
`timescale 1ns/1ps
module pic_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] ir = 8'h00;
    logic       inta = 1'b0;
    logic       int_o, vec_valid, cas_hit;
    logic [7:0] vec;

    always #2.5 clk = ~clk;

    pic_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ir(ir), .inta(inta), .int_o(int_o),
        .vec_valid(vec_valid), .vec(vec), .cas_hit(cas_hit)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [7:0] m_irr, m_isr, m_imr, m_cas;
    logic [4:0] m_base;
    bit         m_aeoi, m_sngl, m_ic4;
    int         m_step;

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit exp_int();
        int c;
        int s;
        c = lowest(m_irr & ~m_imr);
        s = lowest(m_isr);
        return (m_step == 5) && (c < 8) && (c < s);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        int s;
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (!a && d[4]) begin
            m_irr = 0; m_isr = 0; m_imr = 0; m_aeoi = 0;
            m_sngl = d[1]; m_ic4 = d[0]; m_step = 2;
        end else if (a) begin
            case (m_step)
                2: begin m_base = d[7:3]; m_step = !m_sngl ? 3 : (m_ic4 ? 4 : 5); end
                3: begin m_cas = d; m_step = m_ic4 ? 4 : 5; end
                4: begin m_aeoi = d[1]; m_step = 5; end
                5: m_imr = d;
                default: ;
            endcase
        end else if (m_step == 5 && !d[3]) begin
            if (d[7:5] == 3'b001) begin
                s = lowest(m_isr);
                if (s < 8) m_isr[s] = 1'b0;
            end
            if (d[7:5] == 3'b011) m_isr[d[2:0]] = 1'b0;
        end
    endtask

    task automatic rd(logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic pulse(int l);
        @(negedge clk);
        ir[l] = 1'b1;
        @(negedge clk);
        ir[l] = 1'b0;
        m_irr[l] = 1'b1;
    endtask

    task automatic ack(string tag);
        int c;
        bit g;
        @(negedge clk);
        inta = 1'b1;
        #1;
        if (m_step != 5) begin
            chk({tag, " vec_valid uninit"}, vec_valid, 0);
        end else begin
            c = lowest(m_irr & ~m_imr);
            g = exp_int();
            chk({tag, " vec_valid"}, vec_valid, 1);
            chk({tag, " vec"}, vec, {m_base, g ? c[2:0] : 3'd7});
            chk({tag, " cas_hit"}, cas_hit, g && !m_sngl && m_cas[c[2:0]]);
            if (g) begin
                m_irr[c] = 1'b0;
                if (!m_aeoi) m_isr[c] = 1'b1;
            end
        end
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic chk_int(string tag);
        #1 chk({tag, " int_o"}, int_o, exp_int());
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_cas = 0; m_base = 0;
        m_aeoi = 0; m_sngl = 0; m_ic4 = 0; m_step = 0;
        void'($urandom(32'd20251));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and inactivity before setup
        rd(1'b1, v); chk("R1 mask after reset", v, 8'hFF);
        rd(1'b0, v); chk("R1 pending after reset", v, 8'h00);
        pulse(3);
        chk_int("R1 before setup");
        ack("R1");

        // R2: setup sequence, words do not reach the mask
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R2 mask after setup", v, 8'h00);
        rd(1'b0, v); chk("R2 pending cleared", v, 8'h00);
        chk_int("R2 idle");

        // R4, R5, R11: edge latch and register select
        pulse(5);
        rd(1'b0, v); chk("R4 pending bit 5", v, 8'h20);
        chk_int("R5 single request");
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R11 in-service select", v, 8'h00);

        // R3 mask; R7 spurious with line 7 masked
        wr(1'b1, 8'hA0);
        rd(1'b1, v); chk("R3 mask readback", v, 8'hA0);
        chk_int("R3 masked line");
        ack("R7 spurious");
        rd(1'b0, v); chk("R7 in-service unchanged", v, 8'h00);

        // R6 acknowledge
        wr(1'b1, 8'h00);
        chk_int("R3 unmasked");
        ack("R6 line5");
        rd(1'b0, v); chk("R6 in-service set", v, 8'h20);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R6 pending cleared", v, 8'h00);
        wr(1'b0, 8'h0B);

        // R5 nesting priority
        pulse(6); pulse(1);
        chk_int("R5 higher pending");
        ack("R5 line1");
        rd(1'b0, v); chk("R5 nested in-service", v, 8'h22);
        chk_int("R5 lower blocked");

        // R8 EOIs
        wr(1'b0, 8'h61);
        rd(1'b0, v); chk("R8 specific EOI", v, 8'h20);
        chk_int("R8 still blocked");
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R8 nonspecific EOI", v, 8'h00);
        chk_int("R8 unblocked");
        ack("R8 line6");
        wr(1'b0, 8'h20);

        // R10 chained input
        pulse(2); ack("R10 chained line2"); wr(1'b0, 8'h20);
        pulse(4); ack("R10 plain line4"); wr(1'b0, 8'h20);

        // R4 held level does not re-latch
        @(negedge clk); ir[3] = 1'b1;
        @(negedge clk); m_irr[3] = 1'b1;
        chk_int("R4 held level first edge");
        ack("R4 line3");
        wr(1'b0, 8'h20);
        chk_int("R4 held level no relatch");
        @(negedge clk); ir[3] = 1'b0;

        // R9 automatic clearing in single mode, R10 single mode
        wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h03);
        rd(1'b1, v); chk("R2 single-mode mask", v, 8'h00);
        wr(1'b0, 8'h0B);
        pulse(2);
        ack("R9 R10 single line2");
        rd(1'b0, v); chk("R9 no in-service", v, 8'h00);

        // Random phase
        for (int round = 0; round < 3; round++) begin
            logic [7:0] cmap;
            cmap = 8'($urandom);
            wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, cmap);
            wr(1'b1, ($urandom % 2) ? 8'h03 : 8'h01);
            wr(1'b0, 8'h0B);
            for (int k = 0; k < 120; k++) begin
                case ($urandom % 6)
                    0, 1: pulse(int'($urandom % 8));
                    2, 3: ack("R6 random ack");
                    4: if ($urandom % 2) wr(1'b0, 8'h20);
                       else wr(1'b0, 8'h60 | 8'($urandom % 8));
                    default: wr(1'b1, 8'($urandom & $urandom & $urandom));
                endcase
                chk_int("R5 random");
                rd(1'b0, v); chk("R8 random in-service", v, m_isr);
                rd(1'b1, v); chk("R3 random mask", v, m_imr);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule